// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block carries out exception entry for a small 32-bit RISC core. Seven sources can request entry: reset, undefined instruction, software interrupt, prefetch abort, data abort, IRQ and FIQ. The core presents the request lines, its current status word and its current PC (the address of the executing instruction plus 8). While idle, the controller picks one winner by fixed priority. IRQ and FIQ only compete when their disable bits in the status word are clear.

Once a winner is chosen, the controller captures the status word and the PC. It then runs four named states, one cycle each:

- `ST_SAVE` writes the saved-status register of the target mode.
- `ST_MODE` writes the new status word.
- `ST_LINK` writes the target mode's banked link register.
- `ST_JUMP` writes the PC with the vector.

The transitions are `ST_IDLE -> ST_SAVE` when any source wins, then `ST_SAVE -> ST_MODE -> ST_LINK -> ST_JUMP -> ST_IDLE` unconditionally. The core writes its register file from the enable/data pairs and stalls while `busy` is high.

Status word layout used throughout: mode in bits [4:0], state bit T in bit 5, FIQ disable F in bit 6, IRQ disable I in bit 7. All other bits, including the condition flags [31:28], pass through unchanged.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Leaving block reset (`rst_n` rising) performs a reset entry without any request. A high `req_reset` in idle always wins over every other source.
- R2: With several requests in idle, the winner follows this order: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R3: An IRQ request with status bit 7 set, or a FIQ request with status bit 6 set, is ignored. If no other source requests, `busy` and all write enables stay low.
- R4: Target modes are as follows. Reset and software interrupt enter supervisor (10011). Both aborts enter abort (10111). Undefined enters 11011, IRQ enters 10010 and FIQ enters 10001.
- R5: In `ST_SAVE`, `spsr_wr_en` is high, `spsr_wr_mode` is the target mode and `spsr_wr_data` is the whole captured status word. A reset entry writes neither the saved-status nor the link register.
- R6: In `ST_MODE`, `psr_wr_data` is the captured word with the mode field replaced, bit 7 set and bit 5 cleared. Bit 6 is set for FIQ and reset entries and otherwise kept. All other bits are kept.
- R7: In `ST_LINK`, `lr_wr_data` is the captured PC for a data abort and the captured PC minus 4 for undefined, software interrupt, prefetch abort, IRQ and FIQ. `lr_wr_mode` equals the target mode.
- R8: In `ST_JUMP`, `pc_wr_data` is the vector. The vectors are 0x00 reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 IRQ and 0x1C FIQ.
- R9: An entry occupies exactly four cycles after acceptance, with `busy` high and at most one write enable per cycle. Status word and PC are captured at acceptance, so changes to them afterwards have no effect.
- R10: Simultaneous undefined and software interrupt requests resolve to undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined-instruction request |
| req_swi | input | 1 | Software-interrupt request |
| req_pabort | input | 1 | Prefetch-abort request |
| req_dabort | input | 1 | Data-abort request |
| req_irq | input | 1 | IRQ request |
| req_fiq | input | 1 | FIQ request |
| cur_psr | input | 32 | Current status word |
| cur_pc | input | 32 | Current PC (executing instruction + 8) |
| busy | output | 1 | Entry sequence in progress |
| spsr_wr_en | output | 1 | Saved-status write enable |
| spsr_wr_mode | output | 5 | Bank selected for the saved-status write |
| spsr_wr_data | output | 32 | Saved-status write data |
| psr_wr_en | output | 1 | Status word write enable |
| psr_wr_data | output | 32 | New status word |
| lr_wr_en | output | 1 | Link register write enable |
| lr_wr_mode | output | 5 | Bank selected for the link write |
| lr_wr_data | output | 32 | Return address |
| pc_wr_en | output | 1 | PC write enable |
| pc_wr_data | output | 32 | Vector address |

## Verification
A wrong state register shows within one cycle of acceptance: an enable fires out of its slot, two enables fire together, or `busy` drops early. A wrongly captured winner is visible one cycle after acceptance in the saved-status bank, then in the mode field, and finally in the vector four cycles after acceptance. The bench sweeps every combination of the seven request lines against every setting of the two interrupt-disable bits and predicts each write arithmetically. It also corrupts the live status word and PC right after acceptance to expose any missing capture.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int MODE_W  = 5;
    localparam int NUM_SRC = 7;
    localparam int T_BIT   = 5;
    localparam int F_BIT   = 6;
    localparam int I_BIT   = 7;
    localparam int VEC_W   = 8;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

    typedef enum logic [2:0] {
        EK_RESET = 3'd0,
        EK_UNDEF = 3'd1,
        EK_SWI   = 3'd2,
        EK_PABT  = 3'd3,
        EK_DABT  = 3'd4,
        EK_IRQ   = 3'd5,
        EK_FIQ   = 3'd6
    } exc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SAVE = 3'd1,
        ST_MODE = 3'd2,
        ST_LINK = 3'd3,
        ST_JUMP = 3'd4
    } entry_state_e;

    // Priority slot (0 = highest) to exception kind
    function automatic exc_kind_e prio_kind(input int slot);
        exc_kind_e k;
        unique case (slot)
            0:       k = EK_RESET;
            1:       k = EK_DABT;
            2:       k = EK_FIQ;
            3:       k = EK_IRQ;
            4:       k = EK_PABT;
            5:       k = EK_UNDEF;
            default: k = EK_SWI;
        endcase
        return k;
    endfunction

    function automatic logic [MODE_W-1:0] kind_mode(input exc_kind_e k);
        logic [MODE_W-1:0] m;
        unique case (k)
            EK_RESET, EK_SWI: m = MODE_SVC;
            EK_PABT, EK_DABT: m = MODE_ABT;
            EK_UNDEF:         m = MODE_UND;
            EK_IRQ:           m = MODE_IRQ;
            default:          m = MODE_FIQ;
        endcase
        return m;
    endfunction

    function automatic logic [VEC_W-1:0] kind_vector(input exc_kind_e k);
        logic [VEC_W-1:0] v;
        unique case (k)
            EK_RESET: v = 8'h00;
            EK_UNDEF: v = 8'h04;
            EK_SWI:   v = 8'h08;
            EK_PABT:  v = 8'h0C;
            EK_DABT:  v = 8'h10;
            EK_IRQ:   v = 8'h18;
            default:  v = 8'h1C;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
    parameter int N = 7
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_frame.sv
module exc_frame
    import exc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  exc_kind_e            kind,
    input  logic [DATA_W-1:0]    psr,
    input  logic [DATA_W-1:0]    pc,
    output logic [MODE_W-1:0]    target_mode,
    output logic [DATA_W-1:0]    new_psr,
    output logic [DATA_W-1:0]    link,
    output logic [DATA_W-1:0]    vector,
    output logic                 keeps_context
);
    localparam int PAD_W = DATA_W - VEC_W;

    always_comb begin
        target_mode   = kind_mode(kind);
        keeps_context = (kind != EK_RESET);

        new_psr               = psr;
        new_psr[MODE_W-1:0]   = target_mode;
        new_psr[I_BIT]        = 1'b1;
        new_psr[T_BIT]        = 1'b0;
        if (kind == EK_FIQ || kind == EK_RESET)
            new_psr[F_BIT] = 1'b1;

        if (kind == EK_DABT || kind == EK_RESET)
            link = pc;
        else
            link = pc - DATA_W'(4);

        vector = {{PAD_W{1'b0}}, kind_vector(kind)};
    end
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
    import exc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output entry_state_e state
);
    entry_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_SAVE;
            ST_SAVE: nxt = ST_MODE;
            ST_MODE: nxt = ST_LINK;
            ST_LINK: nxt = ST_JUMP;
            ST_JUMP: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_reset,
    input  logic              req_undef,
    input  logic              req_swi,
    input  logic              req_pabort,
    input  logic              req_dabort,
    input  logic              req_irq,
    input  logic              req_fiq,
    input  logic [DATA_W-1:0] cur_psr,
    input  logic [DATA_W-1:0] cur_pc,
    output logic              busy,
    output logic              spsr_wr_en,
    output logic [4:0]        spsr_wr_mode,
    output logic [DATA_W-1:0] spsr_wr_data,
    output logic              psr_wr_en,
    output logic [DATA_W-1:0] psr_wr_data,
    output logic              lr_wr_en,
    output logic [4:0]        lr_wr_mode,
    output logic [DATA_W-1:0] lr_wr_data,
    output logic              pc_wr_en,
    output logic [DATA_W-1:0] pc_wr_data
);
    entry_state_e        state;
    logic [NUM_SRC-1:0]  prio_req;
    logic [NUM_SRC-1:0]  grant;
    logic                any_req;
    logic                accept;
    logic                boot_pend_q;
    exc_kind_e           win_kind;
    exc_kind_e           kind_q;
    logic [DATA_W-1:0]   psr_q;
    logic [DATA_W-1:0]   pc_q;
    logic [MODE_W-1:0]   tgt_mode;
    logic [DATA_W-1:0]   nxt_psr;
    logic [DATA_W-1:0]   ret_addr;
    logic [DATA_W-1:0]   vec_addr;
    logic                keep_ctx;

    // Requests ordered by priority, slot 0 highest
    always_comb begin
        prio_req[0] = req_reset | boot_pend_q;
        prio_req[1] = req_dabort;
        prio_req[2] = req_fiq & ~cur_psr[F_BIT];
        prio_req[3] = req_irq & ~cur_psr[I_BIT];
        prio_req[4] = req_pabort;
        prio_req[5] = req_undef;
        prio_req[6] = req_swi;
    end

    exc_arbiter #(.N(NUM_SRC)) u_arb (
        .req   (prio_req),
        .grant (grant),
        .any   (any_req)
    );

    always_comb begin
        win_kind = EK_RESET;
        for (int i = 0; i < NUM_SRC; i++)
            if (grant[i]) win_kind = prio_kind(i);
    end

    assign accept = (state == ST_IDLE) && any_req;

    exc_seq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .state (state)
    );

    // Pending power-up entry and entry snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_pend_q <= 1'b1;
            kind_q      <= EK_RESET;
            psr_q       <= '0;
            pc_q        <= '0;
        end else if (accept) begin
            boot_pend_q <= 1'b0;
            kind_q      <= win_kind;
            psr_q       <= cur_psr;
            pc_q        <= cur_pc;
        end
    end

    exc_frame #(.DATA_W(DATA_W)) u_frame (
        .kind          (kind_q),
        .psr           (psr_q),
        .pc            (pc_q),
        .target_mode   (tgt_mode),
        .new_psr       (nxt_psr),
        .link          (ret_addr),
        .vector        (vec_addr),
        .keeps_context (keep_ctx)
    );

    // Output process: one register write per sequence state
    always_comb begin
        busy         = (state != ST_IDLE);
        spsr_wr_en   = 1'b0;
        psr_wr_en    = 1'b0;
        lr_wr_en     = 1'b0;
        pc_wr_en     = 1'b0;
        spsr_wr_mode = tgt_mode;
        lr_wr_mode   = tgt_mode;
        spsr_wr_data = psr_q;
        psr_wr_data  = nxt_psr;
        lr_wr_data   = ret_addr;
        pc_wr_data   = vec_addr;
        unique case (state)
            ST_IDLE: ;
            ST_SAVE: spsr_wr_en = keep_ctx;
            ST_MODE: psr_wr_en  = 1'b1;
            ST_LINK: lr_wr_en   = keep_ctx;
            ST_JUMP: pc_wr_en   = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
    import exc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              spsr_wr_en,
    input logic [4:0]        spsr_wr_mode,
    input logic              psr_wr_en,
    input logic [DATA_W-1:0] psr_wr_data,
    input logic              lr_wr_en,
    input logic [4:0]        lr_wr_mode,
    input logic              pc_wr_en,
    input logic [DATA_W-1:0] pc_wr_data
);
    // R9: never two register writes in one cycle
    p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({spsr_wr_en, psr_wr_en, lr_wr_en, pc_wr_en}));

    // R9: status write follows the first busy cycle
    p_mode_after_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> psr_wr_en);

    // R9: PC write two cycles after status write, then idle
    p_jump_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        psr_wr_en |=> ##1 pc_wr_en);

    p_idle_after_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_en |=> !busy);

    // R6: IRQ always disabled on entry; FIQ disabled when entering FIQ mode
    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        psr_wr_en |-> psr_wr_data[I_BIT] && !psr_wr_data[T_BIT]);

    p_fiq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (psr_wr_en && psr_wr_data[MODE_W-1:0] == MODE_FIQ) |-> psr_wr_data[F_BIT]);

    // R4: saved-status bank is never user mode
    p_bank_priv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spsr_wr_en |-> spsr_wr_mode != MODE_USR);

    // R7: link bank equals mode written one cycle earlier
    p_link_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lr_wr_en |-> lr_wr_mode == $past(psr_wr_data[MODE_W-1:0]));

    // R8: vector is word aligned and within the table
    p_vector_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_en |-> (pc_wr_data[1:0] == 2'b00 && pc_wr_data[DATA_W-1:5] == '0));
endmodule

bind exc_entry_ctrl exc_entry_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .spsr_wr_en   (spsr_wr_en),
    .spsr_wr_mode (spsr_wr_mode),
    .psr_wr_en    (psr_wr_en),
    .psr_wr_data  (psr_wr_data),
    .lr_wr_en     (lr_wr_en),
    .lr_wr_mode   (lr_wr_mode),
    .pc_wr_en     (pc_wr_en),
    .pc_wr_data   (pc_wr_data)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  req = '0;   // bit k: 0 reset,1 undef,2 swi,3 pabort,4 dabort,5 irq,6 fiq
    logic [31:0] cur_psr = '0;
    logic [31:0] cur_pc = '0;
    logic        busy, spsr_wr_en, psr_wr_en, lr_wr_en, pc_wr_en;
    logic [4:0]  spsr_wr_mode, lr_wr_mode;
    logic [31:0] spsr_wr_data, psr_wr_data, lr_wr_data, pc_wr_data;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_reset(req[0]), .req_undef(req[1]), .req_swi(req[2]),
        .req_pabort(req[3]), .req_dabort(req[4]), .req_irq(req[5]), .req_fiq(req[6]),
        .cur_psr(cur_psr), .cur_pc(cur_pc), .busy(busy),
        .spsr_wr_en(spsr_wr_en), .spsr_wr_mode(spsr_wr_mode), .spsr_wr_data(spsr_wr_data),
        .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data),
        .lr_wr_en(lr_wr_en), .lr_wr_mode(lr_wr_mode), .lr_wr_data(lr_wr_data),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic int win(input logic [6:0] r, input logic [31:0] p);
        if (r[0])          return 0;
        if (r[4])          return 4;
        if (r[6] && !p[6]) return 6;
        if (r[5] && !p[7]) return 5;
        if (r[3])          return 3;
        if (r[1])          return 1;
        if (r[2])          return 2;
        return 7;
    endfunction

    function automatic logic [4:0] mode_of(input int k);
        case (k)
            0, 2:    return 5'b10011;
            3, 4:    return 5'b10111;
            1:       return 5'b11011;
            5:       return 5'b10010;
            default: return 5'b10001;
        endcase
    endfunction

    function automatic logic [31:0] vec_of(input int k);
        case (k)
            5:       return 32'h18;
            6:       return 32'h1C;
            default: return 32'(k * 4);
        endcase
    endfunction

    function automatic logic [31:0] psr_of(input int k, input logic [31:0] p);
        logic [31:0] n = p;
        n[4:0] = mode_of(k);
        n[7] = 1'b1;
        n[5] = 1'b0;
        if (k == 0 || k == 6) n[6] = 1'b1;
        return n;
    endfunction

    // Called at the negedge after acceptance (sequence state SAVE)
    task automatic follow_entry(input int k, input logic [31:0] p, input logic [31:0] pc,
                                input bool_multi);
        logic [31:0] lr_exp = (k == 4) ? pc : pc - 32'd4;
        bit keep = (k != 0);
        // SAVE
        chk(busy == 1'b1, "R9", "busy in save", 32'(busy), 32'd1);
        chk({spsr_wr_en, psr_wr_en, lr_wr_en, pc_wr_en} == {keep, 3'b000}, "R5",
            "save enables", 32'({spsr_wr_en, psr_wr_en, lr_wr_en, pc_wr_en}), 32'({keep, 3'b000}));
        if (keep) begin
            chk(spsr_wr_mode == mode_of(k), "R4", "saved bank", 32'(spsr_wr_mode), 32'(mode_of(k)));
            chk(spsr_wr_data == p, "R5", "saved status", spsr_wr_data, p);
        end
        // R9: corrupt live inputs after acceptance
        cur_psr = ~p;
        cur_pc  = ~pc;
        @(negedge clk);
        chk(psr_wr_en && !lr_wr_en && !pc_wr_en, "R9", "mode step enable", 32'(psr_wr_en), 32'd1);
        chk(psr_wr_data == psr_of(k, p), "R6", "new status", psr_wr_data, psr_of(k, p));
        chk(psr_wr_data[4:0] == mode_of(k), "R4", "new mode", 32'(psr_wr_data[4:0]), 32'(mode_of(k)));
        @(negedge clk);
        chk(lr_wr_en == keep && !psr_wr_en && !pc_wr_en, "R7", "link enable", 32'(lr_wr_en), 32'(keep));
        if (keep) begin
            chk(lr_wr_data == lr_exp, "R7", "return address", lr_wr_data, lr_exp);
            chk(lr_wr_mode == mode_of(k), "R7", "link bank", 32'(lr_wr_mode), 32'(mode_of(k)));
        end
        @(negedge clk);
        chk(pc_wr_en == 1'b1, "R9", "jump enable", 32'(pc_wr_en), 32'd1);
        chk(pc_wr_data == vec_of(k), "R8", "vector", pc_wr_data, vec_of(k));
        if (bool_multi)
            chk(pc_wr_data == vec_of(k), "R2", "priority winner", pc_wr_data, vec_of(k));
        @(negedge clk);
        chk(!busy && !pc_wr_en, "R9", "idle after four cycles", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cur_psr = 32'hF000_00D0;
        cur_pc  = 32'h0000_2468;
        repeat (3) @(negedge clk);
        chk(!busy && !spsr_wr_en && !psr_wr_en && !lr_wr_en && !pc_wr_en, "R1",
            "outputs quiet in reset", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: power-up entry without request
        chk(busy == 1'b1, "R1", "power-up entry started", 32'(busy), 32'd1);
        follow_entry(0, 32'hF000_00D0, 32'h0000_2468, 1'b0);
        @(negedge clk);
        chk(!busy, "R1", "no second power-up entry", 32'(busy), 32'd0);

        for (int m = 0; m < 128; m++) begin
            for (int mk = 0; mk < 4; mk++) begin
                logic [31:0] p;
                logic [31:0] pc;
                int k;
                p = 32'h5000_0030 ^ (32'(m) << 12);
                p[7] = mk[1];
                p[6] = mk[0];
                pc = 32'h0000_1000 + 32'(m * 16) + 32'(mk * 4);
                cur_psr = p;
                cur_pc  = pc;
                req = 7'(m);
                k = win(7'(m), p);
                @(negedge clk);
                req = '0;
                if (k == 7) begin
                    // R3: masked interrupts (or nothing) start no entry
                    chk(!busy && !spsr_wr_en && !psr_wr_en && !lr_wr_en && !pc_wr_en, "R3",
                        "masked request ignored", 32'(busy), 32'd0);
                end else begin
                    if (m[1] && m[2] && k == 1)
                        chk(spsr_wr_mode == 5'b11011, "R10", "undef over swi",
                            32'(spsr_wr_mode), 32'h1B);
                    if (m[0])
                        chk(k == 0 && spsr_wr_en == 1'b0, "R1", "reset request wins",
                            32'(spsr_wr_en), 32'd0);
                    follow_entry(k, p, pc, $countones(m) > 1);
                end
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule